// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches up to 32 external interrupt pins and turns activity on them into per-line interrupt requests for a processor. Each line has its own sense mode: active-low level, active-high level, falling edge, rising edge, or either edge. Every pin passes through a two-flop synchronizer before any sense logic. Edges are found by comparing consecutive synchronized samples in the controller clock domain.

A detected event sets that line's bit in a shared detect-status register. Software clears the bit by writing a one to it. Enables are changed through two write ports, one that sets bits and one that clears them, so software never needs a read-modify-write. Each interrupt output is the line's status bit gated by its enable.

Register access is a plain 32-bit word interface: a write strobe, an address and write data. Read data is a combinational function of the address.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all enables, detect-status bits, sense fields and interrupt outputs are zero.
- R2: A write to byte offset 0x08 sets every enable bit whose write-data bit is 1; bits written 0 keep their value. A read of offset 0x08 or 0x04 returns the enable vector in bits [N_LINES-1:0].
- R3: A write to offset 0x04 clears every enable bit whose write-data bit is 1; bits written 0 keep their value.
- R4: Line n has a sense register at offset 0x180 + 4*n. Its low 6 bits are stored and read back, upper read bits are zero, and writes for n >= N_LINES are ignored.
- R5: Sense code 0x01 sets the line's detect bit on every cycle the synchronized pin is 0, and code 0x02 on every cycle it is 1.
- R6: Sense code 0x04 detects a 1-to-0 change between consecutive synchronized samples, code 0x08 a 0-to-1 change, and code 0x0C either change.
- R7: Any other sense code, including 0, never sets the detect bit.
- R8: Offset 0x100 reads the latched detect bits. Writing a 1 to a bit clears that latch, and writing 0 leaves it unchanged.
- R9: A detection in the same cycle as a clear of that bit wins, so a level-mode bit stays set while its level remains active.
- R10: Interrupt output n equals detect bit n AND enable bit n.
- R11: A pin change that meets an edge sense code is visible in the detect status after the third rising clock edge that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_LINES | Asynchronous external interrupt pins |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| irq_o | output | N_LINES | Per-line interrupt requests |

## Verification
The main sweep drives every line of a four-line instance through each pin transition pair (0 to 0, 0 to 1, 1 to 0, 1 to 1), under every valid sense code and several invalid ones. The result separates the level modes, which react to a steady state, from the edge modes, which react only to a change and its direction. Invalid codes must stay silent for every pair. Other cases clear a status bit while a level is still active and while it is inactive, which shows that a detection takes priority over a clear. A single rising edge is timed cycle by cycle to pin the synchronizer latency. Overlapping set and clear patterns on the enable ports check that each port touches only its one-bits.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned SENSE_W = 6;
  typedef logic [SENSE_W-1:0] sense_t;

  localparam sense_t SENSE_LVL_LO  = 6'h01;
  localparam sense_t SENSE_LVL_HI  = 6'h02;
  localparam sense_t SENSE_FALL    = 6'h04;
  localparam sense_t SENSE_RISE    = 6'h08;
  localparam sense_t SENSE_ANYEDGE = 6'h0C;

  localparam int unsigned OFS_EN_CLR  = 'h004;
  localparam int unsigned OFS_EN_SET  = 'h008;
  localparam int unsigned OFS_STATUS  = 'h100;
  localparam int unsigned OFS_CFG     = 'h180;
  localparam int unsigned MAX_LINES   = 32;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   level_i,
  input  sense_t mode_i,
  output logic   det_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  logic fall, rise;
  assign fall = prev_q & ~level_i;
  assign rise = ~prev_q & level_i;

  always_comb begin
    unique case (mode_i)
      SENSE_LVL_LO:  det_o = ~level_i;
      SENSE_LVL_HI:  det_o = level_i;
      SENSE_FALL:    det_o = fall;
      SENSE_RISE:    det_o = rise;
      SENSE_ANYEDGE: det_o = fall | rise;
      default:       det_o = 1'b0;
    endcase
  end

  // R7: unknown codes stay silent
  a_r7_unknown_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != SENSE_LVL_LO && mode_i != SENSE_LVL_HI && mode_i != SENSE_FALL &&
     mode_i != SENSE_RISE && mode_i != SENSE_ANYEDGE) |-> !det_o);

  // R6: edge modes need a sample change
  a_r6_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_ANYEDGE && level_i == prev_q) |-> !det_o);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] pin_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [N_LINES-1:0] irq_o
);
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned BLK_W   = ADDR_W - 7;
  localparam logic [BLK_W-1:0] CFG_BLK = BLK_W'(OFS_CFG >> 7);

  logic [N_LINES-1:0] pin_s, det, en_q, stat_q;
  sense_t             cfg_q [N_LINES];

  logic hit_clr, hit_set, hit_stat, hit_cfg;
  logic [IDX_W-1:0] cfg_idx;

  assign hit_clr  = addr_i == ADDR_W'(OFS_EN_CLR);
  assign hit_set  = addr_i == ADDR_W'(OFS_EN_SET);
  assign hit_stat = addr_i == ADDR_W'(OFS_STATUS);
  assign hit_cfg  = (addr_i[ADDR_W-1:7] == CFG_BLK) && (addr_i[1:0] == 2'b00);
  assign cfg_idx  = addr_i[6:2];

  ext_irq_sync #(.WIDTH(N_LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    ext_irq_sense u_sense (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .level_i(pin_s[i]),
      .mode_i (cfg_q[i]),
      .det_o  (det[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[i] <= '0;
      else if (we_i && hit_cfg && cfg_idx == IDX_W'(i)) cfg_q[i] <= wdata_i[SENSE_W-1:0];
    end
  end

  logic [N_LINES-1:0] wbits, stat_clr;
  assign wbits    = wdata_i[N_LINES-1:0];
  assign stat_clr = (we_i && hit_stat) ? wbits : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (we_i && hit_set)      en_q <= en_q | wbits;
      else if (we_i && hit_clr) en_q <= en_q & ~wbits;
      stat_q <= (stat_q & ~stat_clr) | det;  // detection wins over clear
    end
  end

  assign irq_o = stat_q & en_q;

  always_comb begin
    rdata_o = '0;
    if (hit_clr || hit_set) rdata_o[N_LINES-1:0] = en_q;
    else if (hit_stat)      rdata_o[N_LINES-1:0] = stat_q;
    else if (hit_cfg) begin
      for (int i = 0; i < N_LINES; i++)
        if (cfg_idx == IDX_W'(i)) rdata_o[SENSE_W-1:0] = cfg_q[i];
    end
  end

  a_r2_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_set) |=> ((en_q & $past(wbits)) == $past(wbits)));

  a_r3_en_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_clr) |=> ((en_q & $past(wbits)) == '0));

  a_r8_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_stat) |=> ((stat_q & $past(wbits & ~det)) == '0));

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det != '0) |=> ((stat_q & $past(det)) == $past(det)));

  a_r2_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (hit_set || hit_clr)) |=> $stable(en_q));
endmodule

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
  localparam int NL = 4;
  logic clk = 0, rst_n = 0;
  logic [NL-1:0] pin = '0;
  logic we = 0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NL-1:0] irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl #(.N_LINES(NL), .ADDR_W(10)) u_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic bit expect_det(logic [5:0] c, bit a, bit b);
    case (c)
      6'h01: return !a || !b;
      6'h02: return a || b;
      6'h04: return a && !b;
      6'h08: return !a && b;
      6'h0C: return a != b;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [5:0] codes [9] = '{6'h01, 6'h02, 6'h04, 6'h08, 6'h0C, 6'h00, 6'h03, 6'h10, 6'h3F};
    int cnt = 0;
    idle(2); #1 rst_n = 1;

    // R1 reset state
    rd(10'h008, d); chk("R1 enables", d, 0);
    rd(10'h100, d); chk("R1 status", d, 0);
    for (int l = 0; l < NL; l++) begin
      rd(10'(10'h180 + 4*l), d); chk("R1 sense", d, 0);
    end
    chk("R1 irq", 32'(irq), 0);

    // R2/R3 enable ports
    wr(10'h008, 32'h5); rd(10'h008, d); chk("R2 set", d, 32'h5);
    wr(10'h008, 32'h2); rd(10'h004, d); chk("R2 set keeps zeros", d, 32'h7);
    wr(10'h004, 32'h5); rd(10'h008, d); chk("R3 clear", d, 32'h2);
    wr(10'h004, 32'h0); rd(10'h004, d); chk("R3 zero no effect", d, 32'h2);
    wr(10'h004, 32'hF);

    // R4 sense registers
    wr(10'h184, 32'hFFFF_FFEA); rd(10'h184, d); chk("R4 low six bits", d, 32'h2A);
    wr(10'h184, 32'h0);         rd(10'h184, d); chk("R4 rewrite", d, 0);
    wr(10'h190, 32'h3F);        rd(10'h190, d); chk("R4 out of range", d, 0);

    // R5/R6/R7/R10 sweep
    foreach (codes[ci]) begin
      for (int l = 0; l < NL; l++) begin
        for (int ab = 0; ab < 4; ab++) begin
          bit a = ab[1], b = ab[0];
          bit en = cnt[0];
          bit e;
          string tag;
          cnt++;
          wr(10'(10'h180 + 4*l), 0);
          @(negedge clk); pin[l] = a;
          idle(4);
          wr(10'h100, 32'hF);
          wr(10'h004, 32'hF);
          if (en) wr(10'h008, 32'(1 << l));
          wr(10'(10'h180 + 4*l), 32'(codes[ci]));
          @(negedge clk); pin[l] = b;
          idle(4);
          e = expect_det(codes[ci], a, b);
          tag = (codes[ci] == 6'h01 || codes[ci] == 6'h02) ? "R5" :
                (codes[ci] == 6'h04 || codes[ci] == 6'h08 || codes[ci] == 6'h0C) ? "R6" : "R7";
          rd(10'h100, d);
          chk({tag, " detect"}, d, 32'(e) << l);
          chk("R10 irq gate", 32'(irq), 32'(e && en) << l);
          wr(10'(10'h180 + 4*l), 0);
          @(negedge clk); pin[l] = 0;
          idle(3);
        end
      end
    end

    // R8/R9 level re-set vs clear
    wr(10'h100, 32'hF);
    wr(10'h184, 32'h02);
    @(negedge clk); pin[1] = 1; idle(4);
    wr(10'h100, 32'h2); rd(10'h100, d); chk("R9 level beats clear", d, 32'h2);
    @(negedge clk); pin[1] = 0; idle(4);
    rd(10'h100, d); chk("R8 latch holds", d, 32'h2);
    wr(10'h100, 32'h0); rd(10'h100, d); chk("R8 zero keeps", d, 32'h2);
    wr(10'h100, 32'h2); rd(10'h100, d); chk("R8 clear", d, 0);
    wr(10'h184, 32'h0);

    // R11 latency
    wr(10'h180, 32'h08);
    @(negedge clk); addr = 10'h100; pin[0] = 1;
    @(posedge clk); @(posedge clk); #1 chk("R11 not after two edges", rdata, 0);
    @(posedge clk); #1 chk("R11 after three edges", rdata, 32'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule